// File: doc/BRIEF.md
# YUV to RGB Colour Matrix

This block converts a stream of 8-bit luma/chroma samples into 8-bit red, green and blue samples. One Y, U, V triple may enter per clock with a valid flag; the converted triple leaves three clocks later with its own valid flag. Gaps in the input stream are carried through unchanged.

The conversion is a programmable 3x4 signed fixed-point matrix held in twelve 14-bit coefficient registers. Register `4*row + k` holds the Y, U and V multipliers for k = 0, 1, 2 and the additive constant for k = 3. Rows are stored green first, then red, then blue. Multipliers are real factors times 1024, and constants are offsets times 16. The block rounds each row sum to the nearest integer, then saturates it to 0..255. After reset the registers hold a BT.601 set that maps limited-range video (Y 16..235, chroma 16..240) onto full-range RGB. Software may overwrite any entry through a one-cycle write port that takes an index and a data word.

Top module: `yuv2rgb_matrix`

## Requirements
- R1: After reset the twelve entries hold, by index 0..11, 0x4A7, 0x1E6F, 0x1CBF, 0x877, 0x4A7, 0x0, 0x662, 0x3211, 0x4A7, 0x812, 0x0, 0x2EB1, and the outputs follow from those values.
- R2: `out_valid` equals `in_valid` from exactly three clocks earlier, and data leaves in the same cycle as its valid flag.
- R3: A multiplier entry is the low 13 bits of its register, read as two's complement (0x1C00 is -1024); bit 13 of a multiplier entry has no effect.
- R4: A constant entry is the full 14-bit register read as two's complement, and it is weighted by 64 relative to a multiplier product.
- R5: Each row computes floor((Y*m0 + U*m1 + V*m2 + 64*c + 512) / 1024), with samples taken as unsigned.
- R6: A row result below 0 leaves as 0, and a result above 255 leaves as 255.
- R7: Row 0 (entries 0..3) drives `out_g`, row 1 (entries 4..7) drives `out_r` and row 2 (entries 8..11) drives `out_b`. A write on one clock edge applies to every pixel captured on a later edge.
- R8: A write with index 12..15 changes no entry.
- R9: While reset is held, and in the first cycle after it, `out_valid` is low and all colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 4 | Coefficient index, 0..11 valid |
| cfg_data | input | 14 | Coefficient write data |
| out_valid | output | 1 | Output valid, three clocks after input |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
Most coefficient faults do not stay hidden. A corrupted or misindexed entry gives a wrong value on one colour channel for most inputs, so a Y/U/V sweep on the affected row exposes it on the first pixel that leaves after the fault, three clocks after that pixel enters. Rounding and clamping faults only show near the 0 and 255 boundaries and at odd half-values, so those inputs are driven on purpose. A valid pipeline that is off by one stage shows as a valid flag one cycle early or late at the first gap in the input stream.

// File: rtl/yuv2rgb_pkg.sv
package yuv2rgb_pkg;

    localparam int SMP_W    = 8;
    localparam int MUL_W    = 13;
    localparam int OFF_W    = 14;
    localparam int WORD_W   = 14;
    localparam int N_ROWS   = 3;
    localparam int N_TAPS   = 3;
    localparam int ROW_LEN  = N_TAPS + 1;
    localparam int N_REGS   = N_ROWS * ROW_LEN;
    localparam int IDX_W    = 4;
    localparam int FRAC     = 10;
    localparam int OFF_SHL  = 6;
    localparam int PROD_W   = SMP_W + 1 + MUL_W;
    localparam int ACC_W    = PROD_W + 4;
    localparam int PIPE_LAT = 3;

    localparam int ROW_G = 0;
    localparam int ROW_R = 1;
    localparam int ROW_B = 2;

    typedef logic [WORD_W-1:0] cword_t;
    typedef logic [SMP_W-1:0]  smp_t;

    typedef struct packed {
        smp_t y;
        smp_t u;
        smp_t v;
    } yuv_t;

    typedef struct packed {
        logic [N_TAPS-1:0][MUL_W-1:0] mul;
        logic [OFF_W-1:0]             off;
    } row_coef_t;

    function automatic cword_t reset_word(int idx);
        case (idx)
            0:  return cword_t'(14'h04A7);
            1:  return cword_t'(14'h1E6F);
            2:  return cword_t'(14'h1CBF);
            3:  return cword_t'(14'h0877);
            4:  return cword_t'(14'h04A7);
            5:  return cword_t'(14'h0000);
            6:  return cword_t'(14'h0662);
            7:  return cword_t'(14'h3211);
            8:  return cword_t'(14'h04A7);
            9:  return cword_t'(14'h0812);
            10: return cword_t'(14'h0000);
            11: return cword_t'(14'h2EB1);
            default: return '0;
        endcase
    endfunction

    function automatic smp_t saturate(logic signed [ACC_W-1:0] q);
        localparam int MAXV = (1 << SMP_W) - 1;
        if (q < 0)
            return '0;
        else if (q > MAXV)
            return smp_t'(MAXV);
        else
            return q[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/coef_bank.sv
module coef_bank
    import yuv2rgb_pkg::*;
#(
    parameter int NREG = N_REGS,
    parameter int IW   = IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IW-1:0]              idx,
    input  cword_t                     wdata,
    output logic [NREG-1:0][WORD_W-1:0] words
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= reset_word(i);
            else if (we && (idx == IW'(i)))
                words[i] <= wdata;
        end
    end

endmodule

// File: rtl/valid_delay.sv
module valid_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else
            sr <= {sr[DEPTH-2:0], din};
    end

    assign dout = sr[DEPTH-1];

endmodule

// File: rtl/row_mac.sv
module row_mac
    import yuv2rgb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_TAPS-1:0][SMP_W-1:0] smp,
    input  row_coef_t                 coef,
    output smp_t                      chan
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));

    logic signed [N_TAPS-1:0][PROD_W-1:0] prod_q;
    logic signed [OFF_W-1:0]              off_q;
    logic signed [ACC_W-1:0]              acc_d;
    logic signed [ACC_W-1:0]              acc_q;
    logic signed [ACC_W-1:0]              shf;

    // stage 1: one product per tap, offset captured with the same coefficients
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        logic signed [PROD_W-1:0] a_ext;
        logic signed [PROD_W-1:0] b_ext;
        assign a_ext = {{(PROD_W - SMP_W){1'b0}}, smp[t]};
        assign b_ext = {{(PROD_W - MUL_W){coef.mul[t][MUL_W-1]}}, coef.mul[t]};
        always_ff @(posedge clk) begin
            if (rst)
                prod_q[t] <= '0;
            else
                prod_q[t] <= a_ext * b_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            off_q <= '0;
        else
            off_q <= coef.off;
    end

    // stage 2: sum of products, scaled constant and rounding half
    always_comb begin
        acc_d = HALF + (ACC_W'(off_q) <<< OFF_SHL);
        for (int t = 0; t < N_TAPS; t++)
            acc_d = acc_d + ACC_W'($signed(prod_q[t]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    // stage 3: drop fraction and saturate
    assign shf = acc_q >>> FRAC;

    always_ff @(posedge clk) begin
        if (rst)
            chan <= '0;
        else
            chan <= saturate(shf);
    end

endmodule

// File: rtl/yuv2rgb_matrix.sv
module yuv2rgb_matrix
    import yuv2rgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_y,
    input  logic [7:0]        in_u,
    input  logic [7:0]        in_v,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_data,
    output logic              out_valid,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b
);

    logic [N_REGS-1:0][WORD_W-1:0] coef_q;
    logic [N_TAPS-1:0][SMP_W-1:0]  taps;
    smp_t                          chan [N_ROWS];
    yuv_t                          pix;

    coef_bank #(.NREG(N_REGS), .IW(IDX_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_data),
        .words (coef_q)
    );

    assign pix     = '{y: in_y, u: in_u, v: in_v};
    assign taps[0] = pix.y;
    assign taps[1] = pix.u;
    assign taps[2] = pix.v;

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        row_coef_t rc;
        for (genvar t = 0; t < N_TAPS; t++) begin : g_mul
            assign rc.mul[t] = coef_q[r*ROW_LEN + t][MUL_W-1:0];
        end
        assign rc.off = coef_q[r*ROW_LEN + N_TAPS][OFF_W-1:0];

        row_mac u_row (
            .clk  (clk),
            .rst  (rst),
            .smp  (taps),
            .coef (rc),
            .chan (chan[r])
        );
    end

    valid_delay #(.DEPTH(PIPE_LAT)) u_vld (
        .clk  (clk),
        .rst  (rst),
        .din  (in_valid),
        .dout (out_valid)
    );

    assign out_g = chan[ROW_G];
    assign out_r = chan[ROW_R];
    assign out_b = chan[ROW_B];

endmodule

// File: rtl/yuv2rgb_chk.sv
module yuv2rgb_chk
    import yuv2rgb_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          out_valid,
    input logic                          cfg_we,
    input logic [IDX_W-1:0]              cfg_idx,
    input logic [WORD_W-1:0]             cfg_data,
    input logic [N_REGS-1:0][WORD_W-1:0] coef_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    // R8
    bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_idx >= IDX_W'(N_REGS))) |=> $stable(coef_q));

    // R7
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_idx < IDX_W'(N_REGS))) |=> (coef_q[$past(cfg_idx)] == $past(cfg_data)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(coef_q));

endmodule

bind yuv2rgb_matrix yuv2rgb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_data  (cfg_data),
    .coef_q    (coef_q)
);

// File: tb/tb_yuv2rgb_matrix.sv
`timescale 1ns/1ps
module tb_yuv2rgb_matrix;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [13:0] cfg_data = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int total = 0;
    int bad   = 0;

    int mc [12];
    logic       sh_v [3];
    int         sh_r [3], sh_g [3], sh_b [3];
    string      sh_t [3];

    yuv2rgb_matrix dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #2.5 clk = ~clk;

    function automatic int dec(int idx, logic [13:0] w);
        if ((idx % 4) == 3)
            return (w[13] ? int'(w) - 16384 : int'(w));
        else
            return (w[12] ? int'(w[12:0]) - 8192 : int'(w[12:0]));
    endfunction

    function automatic int model(int row, int y, int u, int v);
        int acc, q;
        acc = y*mc[4*row] + u*mc[4*row+1] + v*mc[4*row+2] + 64*mc[4*row+3] + 512;
        q = acc >>> 10;
        if (q < 0) return 0;
        if (q > 255) return 255;
        return q;
    endfunction

    task automatic load_defaults();
        logic [13:0] d [12] = '{14'h04A7, 14'h1E6F, 14'h1CBF, 14'h0877,
                                14'h04A7, 14'h0000, 14'h0662, 14'h3211,
                                14'h04A7, 14'h0812, 14'h0000, 14'h2EB1};
        for (int i = 0; i < 12; i++) mc[i] = dec(i, d[i]);
    endtask

    task automatic check(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic flush_pipe();
        for (int i = 0; i < 3; i++) begin
            sh_v[i] = 1'b0; sh_r[i] = 0; sh_g[i] = 0; sh_b[i] = 0; sh_t[i] = "R2";
        end
    endtask

    // one cycle: check what leaves, then drive the next input
    task automatic tick(string tag, logic pv, int y, int u, int v,
                        logic we, int idx, logic [13:0] data);
        @(negedge clk);
        check("R2", int'(out_valid), int'(sh_v[2]), "out_valid");
        if (sh_v[2]) begin
            check(sh_t[2], out_r, sh_r[2], "out_r");
            check(sh_t[2], out_g, sh_g[2], "out_g");
            check(sh_t[2], out_b, sh_b[2], "out_b");
        end
        for (int i = 2; i > 0; i--) begin
            sh_v[i] = sh_v[i-1]; sh_r[i] = sh_r[i-1]; sh_g[i] = sh_g[i-1];
            sh_b[i] = sh_b[i-1]; sh_t[i] = sh_t[i-1];
        end
        sh_v[0] = pv;
        sh_r[0] = model(1, y, u, v);
        sh_g[0] = model(0, y, u, v);
        sh_b[0] = model(2, y, u, v);
        sh_t[0] = tag;
        in_valid = pv; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
        cfg_we = we; cfg_idx = 4'(idx); cfg_data = data;
        if (we && idx < 12) mc[idx] = dec(idx, data);
    endtask

    task automatic px(string tag, int y, int u, int v);
        tick(tag, 1'b1, y, u, v, 1'b0, 0, '0);
    endtask

    task automatic wr(int idx, logic [13:0] data);
        tick("R7", 1'b0, 0, 0, 0, 1'b1, idx, data);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick("R2", 1'b0, 0, 0, 0, 1'b0, 0, '0);
    endtask

    initial begin
        repeat (20000 * 10) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        load_defaults();
        flush_pipe();
        repeat (3) @(negedge clk);
        // R9: quiet outputs while reset is held
        check("R9", out_valid, 0, "out_valid in reset");
        check("R9", out_r | out_g | out_b, 0, "colour in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R9", out_valid, 0, "out_valid after reset");
        check("R9", out_r | out_g | out_b, 0, "colour after reset");

        // R1: BT.601 reset matrix, near-exhaustive sweep with gaps (R2)
        n = 0;
        for (int y = 0; y < 256; y += 7)
            for (int u = 0; u < 256; u += 7)
                for (int v = 0; v < 256; v += 7) begin
                    if ((n % 5) == 3) idle(1);
                    px("R1", y, u, v);
                    n++;
                end
        // R6: corners of the input cube drive both clamps
        for (int c = 0; c < 8; c++)
            px("R6", (c & 1) ? 255 : 0, (c & 2) ? 255 : 0, (c & 4) ? 255 : 0);
        px("R6", 16, 128, 128);
        px("R6", 235, 128, 128);
        idle(3);

        // R3/R4/R7: G=Y (bit 13 set, ignored), R=255-U, B=V-16
        wr(0, 14'h2400); wr(1, 14'h0000); wr(2, 14'h0000); wr(3, 14'h0000);
        wr(4, 14'h0000); wr(5, 14'h1C00); wr(6, 14'h0000); wr(7, 14'h0FF0);
        wr(8, 14'h0000); wr(9, 14'h0000); wr(10, 14'h0400); wr(11, 14'h3F00);
        for (int y = 0; y < 256; y++) px("R3", y, 255 - y, y);
        for (int v = 0; v < 256; v++) px("R4", v, v, v);
        idle(3);

        // R7: write lands for the next captured pixel
        wr(0, 14'h0800);
        px("R7", 100, 0, 0);
        wr(0, 14'h0400);
        px("R7", 100, 0, 0);
        idle(3);

        // R5: half-weight rounding, plus half offset on red
        wr(0, 14'h0200);
        wr(5, 14'h0200); wr(7, 14'h0008);
        for (int y = 0; y < 256; y++) px("R5", y, y, 0);
        idle(3);

        // R8: writes to indices 12..15 are dropped
        for (int i = 12; i < 16; i++) wr(i, 14'h1FFF);
        for (int y = 0; y < 256; y += 3) px("R8", y, 255 - y, y);
        idle(3);

        // R9: reset mid-stream restores the reset matrix
        px("R9", 50, 60, 70);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", out_valid, 0, "out_valid in reset");
        check("R9", out_r | out_g | out_b, 0, "colour in reset");
        rst = 1'b0;
        load_defaults();
        flush_pipe();
        for (int y = 0; y < 256; y += 5) px("R1", y, (y * 3) & 255, (y * 7) & 255);
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule